// File: doc/BRIEF.md
# Sector-Aligning DMA Transfer Engine

This engine sits between a byte-granular host data stream and a storage port that only moves whole 512-byte sectors. Software opens a transfer session by giving a base address, a mode and a total byte count. In disk mode the base counts 512-byte sectors. In optical mode it counts 2048-byte blocks. The session is then served as one or more chunks. Each chunk names a byte length and a direction. It starts at the session base plus the number of bytes already completed in the session.

For each chunk the engine visits every sector that the byte range touches, in ascending order, and issues one storage command per sector access. On a read it streams whole sectors from storage and hands to the host only the bytes inside the requested range. It drops the head bytes before the start and the surplus after the end. On a write it first reads any sector that the range covers only in part into a local one-sector buffer. It then writes the whole sector back, with host bytes inside the range and buffered bytes outside it. Sectors covered in full are written without a pre-read.

After each chunk the remaining count falls by the chunk length and the completed count rises by the same amount. The session closes with a one-cycle completion pulse when the remaining count reaches zero or goes below it. An error from the storage port aborts the chunk, closes the session and raises a sticky error flag.

Top module: `sector_align_dma`

## Requirements
- R1: After reset the engine is idle: startReady is 1, chunkReady is 0, stCmdValid is 0, xferDone is 0, errFlag is 0.
- R2: A session start loads the base byte address as startBase*512 when startOptical is 0 and as startBase*2048 when it is 1. Each chunk begins at that base plus the session's completed byte count.
- R3: A chunk covering bytes [S, S+L) issues storage commands for sectors S>>9 through (S+L-1)>>9 in ascending order. Each command asserts stCmdValid and holds it until stCmdReady. stCmdWrite=1 means a sector write and 0 means a sector read.
- R4: On a read chunk the host receives exactly the L bytes of the range, in address order. The first S mod 512 bytes of the first sector and all bytes after S+L in the last sector are discarded.
- R5: On a write chunk whose start is not a multiple of 512, the first sector is read before it is written. Its bytes below S mod 512 keep their old values.
- R6: On a write chunk whose end S+L is not a multiple of 512, the last sector is read before it is written. Its bytes from (S+L) mod 512 to the end of the sector keep their old values.
- R7: A sector that the write range covers in full gets a write command with no read before it.
- R8: When a chunk completes, remCount falls by L and doneCount rises by L. A session start sets remCount to startTotal and doneCount to 0.
- R9: When a chunk leaves remCount at zero or below, xferDone is high for exactly one cycle: the cycle after the final byte handshake. The session then closes and chunkReady drops to 0.
- R10: stErr high while a chunk is in progress returns the engine to idle and sets errFlag in the next cycle. It also closes the session. The next accepted session start clears errFlag.
- R11: Start and chunk requests are accepted only while idle. A start request made during a chunk has no effect on the running session's counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Session start request |
| startReady | output | 1 | Engine idle, start can be taken |
| startBase | input | BASE_W | Session base in sectors (disk) or blocks (optical) |
| startOptical | input | 1 | 1 selects 2048-byte block units for the base |
| startTotal | input | LEN_W | Session total byte count |
| chunkValid | input | 1 | Chunk request |
| chunkReady | output | 1 | Idle with an open session |
| chunkLen | input | LEN_W | Chunk byte length (non-zero) |
| chunkWrite | input | 1 | 1 = host-to-storage write, 0 = read |
| hostRdValid | output | 1 | Read byte to host valid |
| hostRdReady | input | 1 | Host accepts read byte |
| hostRdData | output | 8 | Read byte to host |
| hostWrValid | input | 1 | Host write byte valid |
| hostWrReady | output | 1 | Engine accepts host write byte |
| hostWrData | input | 8 | Host write byte |
| stCmdValid | output | 1 | Storage sector command valid |
| stCmdReady | input | 1 | Storage accepts command |
| stCmdWrite | output | 1 | 1 = sector write, 0 = sector read |
| stCmdSector | output | ADDR_W-9 | Sector index of the command |
| stRdValid | input | 1 | Storage read byte valid |
| stRdReady | output | 1 | Engine accepts storage read byte |
| stRdData | input | 8 | Storage read byte |
| stWrValid | output | 1 | Sector write byte valid |
| stWrReady | input | 1 | Storage accepts write byte |
| stWrData | output | 8 | Sector write byte |
| stErr | input | 1 | Storage error, aborts the chunk |
| xferDone | output | 1 | One-cycle session completion pulse |
| errFlag | output | 1 | Sticky error status |
| remCount | output | LEN_W+1 | Signed remaining byte count |
| doneCount | output | ADDR_W | Completed byte count of the session |

## Verification
A chunk accepted at a clock edge shows its first storage command two cycles later, after one cycle of sector dispatch. The updated counts, the idle state and any xferDone pulse appear together in the cycle after the last byte handshake. errFlag rises in the cycle after stErr is sampled. The bench changes inputs just after each rising edge and reads every handshake, count and flag at the falling edge. So each sample falls inside the cycle where the result is due. Its behavioural storage and host models throttle the handshakes with fixed patterns. They compare each command and each host byte against queues built from the requirements, and they compare the written sectors byte for byte against a reference image.

// File: rtl/sectdma_pkg.sv
package sectdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SECT,
    S_PRE_CMD,
    S_PRE_DATA,
    S_MAIN_CMD,
    S_MAIN_DATA
  } state_t;

  typedef struct packed {
    logic loadSession;
    logic loadChunk;
    logic advByte;
    logic nextSector;
    logic finishChunk;
    logic bufWrite;
  } ctrl_t;

endpackage

// File: rtl/sectdma_datapath.sv
module sectdma_datapath
  import sectdma_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int OPT_BYTES  = 2048,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BASE_W     = 16,
  localparam int SECT_SH   = $clog2(SECT_BYTES),
  localparam int OPT_SH    = $clog2(OPT_BYTES),
  localparam int SEC_W     = ADDR_W - SECT_SH
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctl,
  input  logic [BASE_W-1:0]   startBase,
  input  logic                startOptical,
  input  logic [LEN_W-1:0]    startTotal,
  input  logic [LEN_W-1:0]    chunkLen,
  input  logic [7:0]          stRdData,
  input  logic [7:0]          hostWrData,
  output logic                inRange,
  output logic                sectPartial,
  output logic                lastByte,
  output logic                onLastSector,
  output logic                remDepleted,
  output logic [SEC_W-1:0]    stCmdSector,
  output logic [7:0]          stWrData,
  output logic signed [LEN_W:0] remCount,
  output logic [ADDR_W-1:0]   doneCount
);

  logic [ADDR_W-1:0]   baseOff, bufIndex, chunkStart, nStart, absPos, sectStart;
  logic [ADDR_W:0]     chunkEnd, nEnd, nEndM1, sectEnd;
  logic signed [LEN_W:0] remaining, remAfter;
  logic [LEN_W-1:0]    chunkLenQ;
  logic [SEC_W-1:0]    curSector, lastSector;
  logic [SECT_SH-1:0]  byteIdx;
  logic [7:0]          secBuf [SECT_BYTES];

  assign nStart    = baseOff + bufIndex;
  assign nEnd      = {1'b0, nStart} + (ADDR_W+1)'(chunkLen);
  assign nEndM1    = nEnd - {{ADDR_W{1'b0}}, 1'b1};
  assign absPos    = {curSector, byteIdx};
  assign sectStart = {curSector, {SECT_SH{1'b0}}};
  assign sectEnd   = {1'b0, sectStart} + (ADDR_W+1)'(SECT_BYTES);
  assign remAfter  = remaining - $signed({1'b0, chunkLenQ});

  assign inRange      = (absPos >= chunkStart) && ({1'b0, absPos} < chunkEnd);
  assign sectPartial  = (sectStart < chunkStart) || (chunkEnd < sectEnd);
  assign lastByte     = &byteIdx;
  assign onLastSector = (curSector == lastSector);
  assign remDepleted  = remAfter[LEN_W] || (remAfter == '0);
  assign stCmdSector  = curSector;
  assign stWrData     = inRange ? hostWrData : secBuf[byteIdx];
  assign remCount     = remaining;
  assign doneCount    = bufIndex;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseOff    <= '0;
      bufIndex   <= '0;
      remaining  <= '0;
      chunkStart <= '0;
      chunkEnd   <= '0;
      chunkLenQ  <= '0;
      curSector  <= '0;
      lastSector <= '0;
      byteIdx    <= '0;
    end else begin
      if (ctl.loadSession) begin
        baseOff   <= startOptical ? ADDR_W'({startBase, {OPT_SH{1'b0}}})
                                  : ADDR_W'({startBase, {SECT_SH{1'b0}}});
        bufIndex  <= '0;
        remaining <= $signed({1'b0, startTotal});
      end
      if (ctl.loadChunk) begin
        chunkStart <= nStart;
        chunkEnd   <= nEnd;
        chunkLenQ  <= chunkLen;
        curSector  <= SEC_W'(nStart >> SECT_SH);
        lastSector <= SEC_W'(nEndM1 >> SECT_SH);
        byteIdx    <= '0;
      end
      if (ctl.advByte)    byteIdx   <= byteIdx + SECT_SH'(1);
      if (ctl.nextSector) curSector <= curSector + SEC_W'(1);
      if (ctl.finishChunk) begin
        remaining <= remAfter;
        bufIndex  <= bufIndex + ADDR_W'(chunkLenQ);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufWrite) secBuf[byteIdx] <= stRdData;
  end

  // R8
  counts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishChunk |=> (doneCount == $past(doneCount) + ADDR_W'($past(chunkLenQ)))
                     && (remCount == $past(remCount) - $signed({1'b0, $past(chunkLenQ)})));

  // R3
  byte_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advByte && !ctl.loadChunk) |=> $stable(byteIdx));

endmodule

// File: rtl/sectdma_ctrl.sv
module sectdma_ctrl
  import sectdma_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startValid,
  input  logic  chunkValid,
  input  logic  chunkWrite,
  input  logic  stCmdReady,
  input  logic  stRdValid,
  input  logic  hostRdReady,
  input  logic  hostWrValid,
  input  logic  stWrReady,
  input  logic  stErr,
  input  logic  inRange,
  input  logic  sectPartial,
  input  logic  lastByte,
  input  logic  onLastSector,
  input  logic  remDepleted,
  output ctrl_t ctl,
  output logic  startReady,
  output logic  chunkReady,
  output logic  stCmdValid,
  output logic  stCmdWrite,
  output logic  stRdReady,
  output logic  hostRdValid,
  output logic  stWrValid,
  output logic  hostWrReady,
  output logic  xferDone,
  output logic  errFlag
);

  state_t state, stateNx;
  logic   sessOpen, wrQ, doneQ, errQ, abort, byteHs;

  assign startReady = (state == S_IDLE);
  assign chunkReady = (state == S_IDLE) && sessOpen && !startValid;
  assign abort      = stErr && (state != S_IDLE);
  assign xferDone   = doneQ;
  assign errFlag    = errQ;

  always_comb begin
    stateNx     = state;
    ctl         = '0;
    stCmdValid  = 1'b0;
    stCmdWrite  = 1'b0;
    stRdReady   = 1'b0;
    hostRdValid = 1'b0;
    stWrValid   = 1'b0;
    hostWrReady = 1'b0;
    byteHs      = 1'b0;
    ctl.loadSession = startValid && startReady;
    ctl.loadChunk   = chunkValid && chunkReady;
    case (state)
      S_IDLE:     if (ctl.loadChunk) stateNx = S_SECT;
      S_SECT:     stateNx = (wrQ && sectPartial) ? S_PRE_CMD : S_MAIN_CMD;
      S_PRE_CMD: begin
        stCmdValid = 1'b1;
        if (stCmdReady) stateNx = S_PRE_DATA;
      end
      S_PRE_DATA: begin
        stRdReady    = 1'b1;
        byteHs       = stRdValid;
        ctl.bufWrite = byteHs;
        if (byteHs && lastByte) stateNx = S_MAIN_CMD;
      end
      S_MAIN_CMD: begin
        stCmdValid = 1'b1;
        stCmdWrite = wrQ;
        if (stCmdReady) stateNx = S_MAIN_DATA;
      end
      S_MAIN_DATA: begin
        if (wrQ) begin
          stWrValid   = inRange ? hostWrValid : 1'b1;
          hostWrReady = inRange && stWrReady;
          byteHs      = stWrValid && stWrReady;
        end else begin
          hostRdValid = stRdValid && inRange;
          stRdReady   = inRange ? hostRdReady : 1'b1;
          byteHs      = stRdValid && stRdReady;
        end
        if (byteHs && lastByte) begin
          if (onLastSector) begin
            ctl.finishChunk = 1'b1;
            stateNx = S_IDLE;
          end else begin
            ctl.nextSector = 1'b1;
            stateNx = S_SECT;
          end
        end
      end
      default: stateNx = S_IDLE;
    endcase
    ctl.advByte = byteHs;
    if (abort) begin
      stateNx         = S_IDLE;
      ctl.finishChunk = 1'b0;
      ctl.nextSector  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      sessOpen <= 1'b0;
      wrQ      <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      state <= stateNx;
      doneQ <= ctl.finishChunk && remDepleted;
      if (ctl.loadChunk) wrQ <= chunkWrite;
      if (ctl.loadSession)                        sessOpen <= 1'b1;
      else if (abort)                             sessOpen <= 1'b0;
      else if (ctl.finishChunk && remDepleted)    sessOpen <= 1'b0;
      if (ctl.loadSession) errQ <= 1'b0;
      else if (abort)      errQ <= 1'b1;
    end
  end

  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stErr && !startReady) |=> (errFlag && startReady && !chunkReady));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (startReady && !sessOpen));

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stCmdValid && !stCmdReady && !stErr) |=> (stCmdValid && $stable(stCmdWrite)));

  // R7
  prefetch_need_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PRE_CMD) |-> (sectPartial && wrQ));

endmodule

// File: rtl/sector_align_dma.sv
module sector_align_dma
  import sectdma_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int OPT_BYTES  = 2048,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BASE_W     = 16,
  localparam int SEC_W     = ADDR_W - $clog2(SECT_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startValid,
  output logic                  startReady,
  input  logic [BASE_W-1:0]     startBase,
  input  logic                  startOptical,
  input  logic [LEN_W-1:0]      startTotal,
  input  logic                  chunkValid,
  output logic                  chunkReady,
  input  logic [LEN_W-1:0]      chunkLen,
  input  logic                  chunkWrite,
  output logic                  hostRdValid,
  input  logic                  hostRdReady,
  output logic [7:0]            hostRdData,
  input  logic                  hostWrValid,
  output logic                  hostWrReady,
  input  logic [7:0]            hostWrData,
  output logic                  stCmdValid,
  input  logic                  stCmdReady,
  output logic                  stCmdWrite,
  output logic [SEC_W-1:0]      stCmdSector,
  input  logic                  stRdValid,
  output logic                  stRdReady,
  input  logic [7:0]            stRdData,
  output logic                  stWrValid,
  input  logic                  stWrReady,
  output logic [7:0]            stWrData,
  input  logic                  stErr,
  output logic                  xferDone,
  output logic                  errFlag,
  output logic signed [LEN_W:0] remCount,
  output logic [ADDR_W-1:0]     doneCount
);

  ctrl_t ctl;
  logic  inRange, sectPartial, lastByte, onLastSector, remDepleted;

  assign hostRdData = stRdData;

  sectdma_ctrl u_ctrl (
    .clk, .rstN, .startValid, .chunkValid, .chunkWrite, .stCmdReady,
    .stRdValid, .hostRdReady, .hostWrValid, .stWrReady, .stErr,
    .inRange, .sectPartial, .lastByte, .onLastSector, .remDepleted,
    .ctl, .startReady, .chunkReady, .stCmdValid, .stCmdWrite, .stRdReady,
    .hostRdValid, .stWrValid, .hostWrReady, .xferDone, .errFlag
  );

  sectdma_datapath #(
    .SECT_BYTES(SECT_BYTES), .OPT_BYTES(OPT_BYTES), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .BASE_W(BASE_W)
  ) u_dp (
    .clk, .rstN, .ctl, .startBase, .startOptical, .startTotal, .chunkLen,
    .stRdData, .hostWrData, .inRange, .sectPartial, .lastByte,
    .onLastSector, .remDepleted, .stCmdSector, .stWrData, .remCount, .doneCount
  );

endmodule

// File: tb/tb_sector_align_dma.sv
`timescale 1ns/100ps
module tb_sector_align_dma;

  localparam int SB = 512;
  localparam int MEMB = 16384;

  logic clk = 1'b0, rstN = 1'b0;
  logic startValid = 0, startOptical = 0, chunkValid = 0, chunkWrite = 0;
  logic [15:0] startBase = 0, startTotal = 0, chunkLen = 0;
  logic hostRdReady = 0, hostWrValid = 0, stCmdReady = 0, stRdValid = 0;
  logic stWrReady = 0, stErr = 0;
  logic [7:0] hostWrData = 0, stRdData = 0;
  logic startReady, chunkReady, hostRdValid, hostWrReady, stCmdValid, stCmdWrite;
  logic stRdReady, stWrValid, xferDone, errFlag;
  logic [7:0] hostRdData, stWrData;
  logic [22:0] stCmdSector;
  logic signed [16:0] remCount;
  logic [31:0] doneCount;

  always #2.5 clk = ~clk;

  sector_align_dma dut (.*);

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  logic [7:0] stor [MEMB];
  logic [7:0] refm [MEMB];
  int  expCmdSec[$];
  bit  expCmdWr[$];
  logic [7:0] expRd[$];
  logic [7:0] srcWr[$];
  int sessBase = 0, completed = 0, remaining = 0;

  task automatic check(string req, string what, longint act, longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // storage model
  initial begin
    int mode = 0, sec = 0, k = 0, cyc = 0, cS = 0;
    bit cHs, cW, rHs, wHs, eS;
    logic [7:0] wd;
    forever begin
      @(negedge clk);
      cHs = stCmdValid && stCmdReady; cW = stCmdWrite; cS = int'(stCmdSector);
      rHs = stRdValid && stRdReady; wHs = stWrValid && stWrReady; wd = stWrData;
      eS = stErr;
      @(posedge clk); #1;
      cyc++;
      if (eS) mode = 0;
      else begin
        if (cHs) begin
          if (expCmdSec.size() == 0) check("R3", "unexpected command sector", cS, -1);
          else begin
            check("R3", "command sector", cS, expCmdSec.pop_front());
            check("R7", "command direction (R5 R6 pre-read order)", cW, expCmdWr.pop_front());
          end
          mode = cW ? 2 : 1; sec = cS; k = 0;
        end
        if (rHs) begin k++; if (k == SB) mode = 0; end
        if (wHs) begin stor[sec*SB+k] = wd; k++; if (k == SB) mode = 0; end
      end
      stCmdReady = (mode == 0);
      stRdValid  = (mode == 1) && (cyc % 5 != 3);
      stRdData   = (mode == 1) ? stor[sec*SB+k] : 8'h00;
      stWrReady  = (mode == 2) && (cyc % 7 != 4);
    end
  end

  // host read sink
  initial begin
    int cyc = 0;
    bit hs;
    logic [7:0] d;
    forever begin
      @(negedge clk);
      hs = hostRdValid && hostRdReady; d = hostRdData;
      @(posedge clk); #1;
      cyc++;
      if (hs) begin
        if (expRd.size() == 0) check("R4", "extra host read byte", d, -1);
        else check("R4", "host read byte", d, expRd.pop_front());
      end
      hostRdReady = (cyc % 3 != 1);
    end
  end

  // host write source
  initial begin
    int cyc = 0;
    bit hs;
    forever begin
      @(negedge clk);
      hs = hostWrValid && hostWrReady;
      @(posedge clk); #1;
      cyc++;
      if (hs && srcWr.size() > 0) void'(srcWr.pop_front());
      hostWrValid = (srcWr.size() > 0) && (cyc % 4 != 2);
      hostWrData  = (srcWr.size() > 0) ? srcWr[0] : 8'h00;
    end
  end

  task automatic startSession(int base, bit opt, int total);
    @(posedge clk); #1;
    startValid = 1; startBase = 16'(base); startOptical = opt; startTotal = 16'(total);
    forever begin
      @(negedge clk);
      if (startReady) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    startValid = 0;
    sessBase = opt ? base * 2048 : base * SB;
    completed = 0; remaining = total;
    @(negedge clk);
    check("R8", "remCount after start", longint'(remCount), remaining);
    check("R8", "doneCount after start", doneCount, 0);
  endtask

  task automatic acceptChunk(int len, bit wr);
    @(posedge clk); #1;
    chunkValid = 1; chunkLen = 16'(len); chunkWrite = wr;
    forever begin
      @(negedge clk);
      if (chunkReady) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    chunkValid = 0;
  endtask

  task automatic runChunk(int len, bit wr, bit poke);
    int st = sessBase + completed;
    int en = st + len;
    int s0 = st / SB;
    int s1 = (en - 1) / SB;
    bit expDone;
    for (int s = s0; s <= s1; s++) begin
      if (wr && ((s*SB < st) || ((s+1)*SB > en))) begin
        expCmdSec.push_back(s); expCmdWr.push_back(0);
      end
      expCmdSec.push_back(s); expCmdWr.push_back(wr);
    end
    for (int i = st; i < en; i++) begin
      if (wr) begin
        logic [7:0] d = 8'((i * 13 + len + 5) & 255);
        srcWr.push_back(d); refm[i] = d;
      end else expRd.push_back(refm[i]);
    end
    acceptChunk(len, wr);
    @(negedge clk);
    check("R11", "startReady while busy", startReady, 0);
    check("R11", "chunkReady while busy", chunkReady, 0);
    if (poke) begin
      @(posedge clk); #1;
      startValid = 1; startBase = 16'd99; startTotal = 16'd9999;
      repeat (10) @(posedge clk);
      #1 startValid = 0;
    end
    do @(negedge clk); while (!startReady);
    completed += len; remaining -= len;
    expDone = (remaining <= 0);
    check("R9", "xferDone on the idle cycle", xferDone, expDone);
    check("R9", "chunkReady after chunk", chunkReady, !expDone);
    check("R8", "remCount after chunk (R11 start ignored)", longint'(remCount), remaining);
    check("R8", "doneCount after chunk", doneCount, completed);
    check("R3", "commands left", expCmdSec.size(), 0);
    check("R4", "read bytes left", expRd.size(), 0);
    check("R5", "write bytes left", srcWr.size(), 0);
    if (wr) begin
      int bad = 0, firstBad = -1;
      for (int i = s0*SB; i < (s1+1)*SB; i++)
        if (stor[i] !== refm[i]) begin bad++; if (firstBad < 0) firstBad = i; end
      check("R6", "storage image mismatches (R5 R7)", bad, 0);
      if (bad != 0) check("R6", "first bad byte address", firstBad, -1);
    end
    @(negedge clk);
    check("R9", "xferDone lasts one cycle", xferDone, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual expired expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < MEMB; i++) begin
      stor[i] = 8'(((i * 7 + 3) ^ (i >> 8)) & 255);
      refm[i] = stor[i];
    end
    repeat (5) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1
    check("R1", "startReady", startReady, 1);
    check("R1", "chunkReady", chunkReady, 0);
    check("R1", "stCmdValid", stCmdValid, 0);
    check("R1", "xferDone", xferDone, 0);
    check("R1", "errFlag", errFlag, 0);

    // disk read: aligned head then unaligned head, two chunks (R2 R4)
    startSession(2, 0, 700);
    runChunk(300, 0, 0);
    runChunk(400, 0, 0);

    // optical base: block 2 = byte 4096 = sector 8 (R2)
    startSession(2, 1, 100);
    runChunk(100, 0, 0);

    // writes with partial head, full middle and partial tail (R5 R6 R7), start ignored while busy (R11)
    startSession(4, 0, 1400);
    runChunk(200, 1, 1);
    runChunk(1200, 1, 0);

    // fully aligned write, no pre-read (R7)
    startSession(10, 0, 1024);
    runChunk(1024, 1, 0);

    // chunk longer than remaining: completes below zero (R9)
    startSession(12, 0, 100);
    runChunk(200, 0, 0);

    // storage error mid-chunk (R10)
    startSession(20, 0, 512);
    expCmdSec.push_back(20); expCmdWr.push_back(0);
    for (int i = 20*SB; i < 21*SB; i++) expRd.push_back(refm[i]);
    acceptChunk(512, 0);
    repeat (40) @(posedge clk);
    #1 stErr = 1;
    @(posedge clk);
    #1 stErr = 0;
    @(negedge clk);
    check("R10", "errFlag after error", errFlag, 1);
    check("R10", "idle after error", startReady, 1);
    check("R10", "session closed after error", chunkReady, 0);
    repeat (3) @(posedge clk);
    expRd.delete(); expCmdSec.delete(); expCmdWr.delete();
    startSession(1, 0, 512);
    check("R10", "errFlag cleared by start", errFlag, 0);
    runChunk(512, 0, 0);

    repeat (5) @(posedge clk);
    summary();
  end

endmodule